// File: doc/BRIEF.md
# Parallel Modulation Port Formatter

This block accepts modulation words from an external source over an 18-bit parallel port and converts each one into the frequency, phase and amplitude control values for a direct digital synthesizer core. Every word holds a 16-bit data field and a 2-bit destination code. The destination code chooses which control value, or pair of values, the data field drives. Any control value that the current destination does not drive takes its value from a static register input.

The block also produces the port's data clock, which runs at one quarter of the sample clock rate. A source outside the block presents a word and the transmit-enable level, and the block captures both on the rising edge of that clock. While transmit enable is low, the port ignores new words. A control input decides whether the data field is then cleared or keeps its last value. The destination code keeps its last value in both cases. The formatted values reach the sample-clock outputs after a fixed delay.

Top module: `pmod_formatter`

## Requirements
- R1: The port word is split with bits 17:2 as the 16-bit data field and bits 1:0 as the destination code: 00 amplitude, 01 phase, 10 frequency, 11 polar.
- R2: `data_clk` is low for two sample clocks and then high for two sample clocks, starting low after reset. The port inputs, the static values, the gain and the idle mode are all captured on the sample clock edge where `data_clk` rises.
- R3: When `tx_en` is low at capture, `word_in` is ignored. The data field becomes zero if `zero_on_idle` is 1, and it keeps its previous value if `zero_on_idle` is 0.
- R4: When `tx_en` is low at capture, the destination code keeps its previous value, whatever the setting of `zero_on_idle`.
- R5: For destination 00, `amp_out` equals data bits 15:2. Data bits 1:0 have no effect.
- R6: For destination 01, `phase_out` equals the full 16-bit data field.
- R7: For destination 10, `freq_out` equals the data field zero-extended to 32 bits and shifted left by `fm_gain` places. With gain 0 the data sits on bit 0, and with gain 15 its top bit lands on bit 30.
- R8: For destination 11, `amp_out` is {data[15:8], static_amp[5:0]} and `phase_out` is {data[7:0], static_phase[7:0]}.
- R9: A control output that the destination does not drive equals the static value captured at the same edge.
- R10: The result of a capture appears on the outputs exactly 4 sample clocks after the capture edge. The outputs change only on edges where `data_clk` rises.
- R11: While reset is asserted and right after it is released, `freq_out`, `phase_out`, `amp_out` and `data_clk` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| word_in | input | 18 | Port word: data 17:2, destination 1:0 |
| tx_en | input | 1 | Transmit enable; when low, new words are ignored |
| zero_on_idle | input | 1 | 1: clear the data while idle; 0: hold the data while idle |
| fm_gain | input | 4 | Left shift applied to frequency data |
| static_freq | input | 32 | Frequency value used when the port does not drive frequency |
| static_phase | input | 16 | Static phase; its low byte fills polar phase |
| static_amp | input | 14 | Static amplitude; bits 5:0 fill polar amplitude |
| data_clk | output | 1 | Quarter-rate data clock |
| freq_out | output | 32 | Frequency control value |
| phase_out | output | 16 | Phase control value |
| amp_out | output | 14 | Amplitude control value |

## Verification
A word captured at a rising edge of `data_clk` must appear on the outputs at the next rising edge, which is four sample clocks later. The bench therefore compares each expected item half a clock after the rise that follows its capture. It then checks the same value again two clocks later, which shows that nothing moves between rising edges. The driver changes inputs only half a clock after `data_clk` falls, so every input is stable around the capture edge. The expected values come from a model of the hold and zero behaviour that the driver updates once per capture.

// File: rtl/pmod_pkg.sv
package pmod_pkg;
    localparam int DATA_W  = 16;
    localparam int CODE_W  = 2;
    localparam int WORD_W  = DATA_W + CODE_W;
    localparam int FREQ_W  = 32;
    localparam int PHASE_W = 16;
    localparam int AMP_W   = 14;
    localparam int GAIN_W  = 4;
    localparam int POL_W   = DATA_W / 2;
    localparam int CNT_W   = 2;

    typedef enum logic [CODE_W-1:0] {
        DST_AMP   = 2'b00,
        DST_PHASE = 2'b01,
        DST_FREQ  = 2'b10,
        DST_POLAR = 2'b11
    } dest_e;

    typedef struct packed {
        logic [DATA_W-1:0]  data;
        dest_e              dest;
        logic [GAIN_W-1:0]  gain;
        logic [FREQ_W-1:0]  s_freq;
        logic [PHASE_W-1:0] s_phase;
        logic [AMP_W-1:0]   s_amp;
    } cap_t;

    typedef struct packed {
        logic [FREQ_W-1:0]  freq;
        logic [PHASE_W-1:0] phase;
        logic [AMP_W-1:0]   amp;
    } ctrl_t;
endpackage

// File: rtl/pmod_clkgen.sv
module pmod_clkgen
    import pmod_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    output logic data_clk,
    output logic strobe
);
    localparam logic [CNT_W-1:0] PRE_RISE = CNT_W'((1 << (CNT_W - 1)) - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.cnt = s_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign data_clk = s_q.cnt[CNT_W-1];
    assign strobe   = (s_q.cnt == PRE_RISE);
endmodule

// File: rtl/pmod_capture.sv
module pmod_capture
    import pmod_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               strobe,
    input  logic [WORD_W-1:0]  word_in,
    input  logic               tx_en,
    input  logic               zero_on_idle,
    input  logic [GAIN_W-1:0]  fm_gain,
    input  logic [FREQ_W-1:0]  static_freq,
    input  logic [PHASE_W-1:0] static_phase,
    input  logic [AMP_W-1:0]   static_amp,
    output cap_t               cap
);
    cap_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (strobe) begin
            c_d.gain    = fm_gain;
            c_d.s_freq  = static_freq;
            c_d.s_phase = static_phase;
            c_d.s_amp   = static_amp;
            if (tx_en) begin
                c_d.data = word_in[WORD_W-1 -: DATA_W];
                c_d.dest = dest_e'(word_in[CODE_W-1:0]);
            end else if (zero_on_idle) begin
                c_d.data = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign cap = c_q;
endmodule

// File: rtl/pmod_map.sv
module pmod_map
    import pmod_pkg::*;
(
    input  cap_t  cap,
    output ctrl_t ctrl
);
    always_comb begin
        ctrl.freq  = cap.s_freq;
        ctrl.phase = cap.s_phase;
        ctrl.amp   = cap.s_amp;
        case (cap.dest)
            DST_AMP:   ctrl.amp   = cap.data[DATA_W-1 -: AMP_W];
            DST_PHASE: ctrl.phase = cap.data[DATA_W-1 -: PHASE_W];
            DST_FREQ:  ctrl.freq  = FREQ_W'(cap.data) << cap.gain;
            DST_POLAR: begin
                ctrl.amp   = {cap.data[DATA_W-1 -: POL_W], cap.s_amp[AMP_W-POL_W-1:0]};
                ctrl.phase = {cap.data[POL_W-1:0], cap.s_phase[PHASE_W-POL_W-1:0]};
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/pmod_delay.sv
module pmod_delay
    import pmod_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic  clk,
    input  logic  rst_n,
    input  ctrl_t din,
    output ctrl_t dout
);
    ctrl_t st_d [DEPTH];
    ctrl_t st_q [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
        if (i == 0) begin : g_head
            always_comb st_d[i] = din;
        end else begin : g_tail
            always_comb st_d[i] = st_q[i-1];
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st_q[i] <= '0;
            else        st_q[i] <= st_d[i];
        end
    end

    assign dout = st_q[DEPTH-1];
endmodule

// File: rtl/pmod_formatter.sv
module pmod_formatter
    import pmod_pkg::*;
#(
    parameter int LATENCY = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [WORD_W-1:0]  word_in,
    input  logic               tx_en,
    input  logic               zero_on_idle,
    input  logic [GAIN_W-1:0]  fm_gain,
    input  logic [FREQ_W-1:0]  static_freq,
    input  logic [PHASE_W-1:0] static_phase,
    input  logic [AMP_W-1:0]   static_amp,
    output logic               data_clk,
    output logic [FREQ_W-1:0]  freq_out,
    output logic [PHASE_W-1:0] phase_out,
    output logic [AMP_W-1:0]   amp_out
);
    localparam int STAGES = LATENCY;

    logic              strobe;
    cap_t              cap;
    ctrl_t             mapped;
    ctrl_t             delayed;
    logic [DATA_W-1:0] cap_data;
    logic [CODE_W-1:0] cap_dest;

    pmod_clkgen u_clk (
        .clk      (clk),
        .rst_n    (rst_n),
        .data_clk (data_clk),
        .strobe   (strobe)
    );

    pmod_capture u_cap (
        .clk          (clk),
        .rst_n        (rst_n),
        .strobe       (strobe),
        .word_in      (word_in),
        .tx_en        (tx_en),
        .zero_on_idle (zero_on_idle),
        .fm_gain      (fm_gain),
        .static_freq  (static_freq),
        .static_phase (static_phase),
        .static_amp   (static_amp),
        .cap          (cap)
    );

    pmod_map u_map (
        .cap  (cap),
        .ctrl (mapped)
    );

    pmod_delay #(.DEPTH(STAGES)) u_dly (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (mapped),
        .dout  (delayed)
    );

    assign cap_data  = cap.data;
    assign cap_dest  = cap.dest;
    assign freq_out  = delayed.freq;
    assign phase_out = delayed.phase;
    assign amp_out   = delayed.amp;
endmodule

// File: rtl/pmod_checker.sv
module pmod_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        data_clk,
    input logic        strobe,
    input logic        tx_en,
    input logic        zero_on_idle,
    input logic [15:0] cap_data,
    input logic [1:0]  cap_dest,
    input logic [31:0] freq_out,
    input logic [15:0] phase_out,
    input logic [13:0] amp_out
);
    AST_DCLK_HIGH_TWO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(data_clk) |=> data_clk); // R2
    AST_DCLK_LOW_TWO: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(data_clk) |=> !data_clk); // R2
    AST_CAPTURE_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> $rose(data_clk)); // R2
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && !tx_en && zero_on_idle) |=> (cap_data == 16'h0)); // R3
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && !tx_en && !zero_on_idle) |=> $stable(cap_data)); // R3
    AST_DEST_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && !tx_en) |=> $stable(cap_dest)); // R4
    AST_OUT_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(data_clk) |-> ($stable(freq_out) && $stable(phase_out) && $stable(amp_out))); // R10
endmodule

bind pmod_formatter pmod_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .data_clk     (data_clk),
    .strobe       (strobe),
    .tx_en        (tx_en),
    .zero_on_idle (zero_on_idle),
    .cap_data     (cap_data),
    .cap_dest     (cap_dest),
    .freq_out     (freq_out),
    .phase_out    (phase_out),
    .amp_out      (amp_out)
);

// File: tb/sim_pmod_formatter.sv
module sim_pmod_formatter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [17:0] word_in = '0;
    logic        tx_en = 1'b0;
    logic        zero_on_idle = 1'b0;
    logic [3:0]  fm_gain = '0;
    logic [31:0] static_freq = '0;
    logic [15:0] static_phase = '0;
    logic [13:0] static_amp = '0;
    logic        data_clk;
    logic [31:0] freq_out;
    logic [15:0] phase_out;
    logic [13:0] amp_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    typedef struct {
        logic [31:0] f;
        logic [15:0] p;
        logic [13:0] a;
        string       tag;
    } item_t;

    item_t q[$];
    logic [15:0] m_data = '0;
    logic [1:0]  m_dest = '0;

    always #5 clk = ~clk;

    pmod_formatter u0 (
        .clk(clk), .rst_n(rst_n), .word_in(word_in), .tx_en(tx_en),
        .zero_on_idle(zero_on_idle), .fm_gain(fm_gain), .static_freq(static_freq),
        .static_phase(static_phase), .static_amp(static_amp), .data_clk(data_clk),
        .freq_out(freq_out), .phase_out(phase_out), .amp_out(amp_out)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cmp(input item_t it, input string when);
        check(freq_out == it.f, {it.tag, " freq ", when}, 64'(freq_out), 64'(it.f));
        check(phase_out == it.p, {it.tag, " phase ", when}, 64'(phase_out), 64'(it.p));
        check(amp_out == it.a, {it.tag, " amp ", when}, 64'(amp_out), 64'(it.a));
    endtask

    task automatic send(input logic [17:0] w, input bit tx, input bit zr, input logic [3:0] g,
                        input logic [31:0] sf, input logic [15:0] sp, input logic [13:0] sa,
                        input string tag);
        item_t it;
        @(negedge data_clk);
        @(negedge clk);
        word_in = w; tx_en = tx; zero_on_idle = zr; fm_gain = g;
        static_freq = sf; static_phase = sp; static_amp = sa;
        if (tx) begin
            m_data = w[17:2];
            m_dest = w[1:0];
        end else if (zr) begin
            m_data = '0;
        end
        it.f = sf; it.p = sp; it.a = sa; it.tag = tag;
        case (m_dest)
            2'b00: it.a = m_data[15:2];
            2'b01: it.p = m_data;
            2'b10: it.f = {16'h0, m_data} << g;
            default: begin
                it.a = {m_data[15:8], sa[5:0]};
                it.p = {m_data[7:0], sp[7:0]};
            end
        endcase
        q.push_back(it);
    endtask

    // Monitor: result of a capture is due at the following data_clk rise (R10)
    initial begin
        item_t cur;
        bit have = 0;
        @(posedge rst_n);
        forever begin
            @(posedge data_clk);
            @(negedge clk);
            if (have) begin
                cmp(cur, "at due edge");
                @(negedge clk);
                @(negedge clk);
                cmp(cur, "R10 held");
            end
            have = 0;
            if (q.size() > 0) begin
                cur = q.pop_front();
                have = 1;
            end
        end
    end

    initial begin
        realtime t_rise, t_fall, t_next;
        repeat (3) @(negedge clk);
        // R11: reset state
        check(data_clk == 1'b0, "R11 data_clk", 64'(data_clk), 64'h0);
        check(freq_out == 32'h0 && phase_out == 16'h0 && amp_out == 14'h0,
              "R11 outputs", {freq_out, phase_out, amp_out[13:0], 2'b0}, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check(freq_out == 32'h0 && phase_out == 16'h0 && amp_out == 14'h0,
              "R11 after release", {freq_out, phase_out, amp_out[13:0], 2'b0}, 64'h0);
        // R2: period and duty
        @(posedge data_clk); t_rise = $realtime;
        @(negedge data_clk); t_fall = $realtime;
        @(posedge data_clk); t_next = $realtime;
        check((t_next - t_rise) == 40.0, "R2 period", 64'(int'(t_next - t_rise)), 64'd40);
        check((t_fall - t_rise) == 20.0, "R2 high time", 64'(int'(t_fall - t_rise)), 64'd20);

        send({16'hABCD, 2'b00}, 1, 0, 4'd0, 32'h1111_2222, 16'h3344, 14'h0155, "R5 R1 R9 amplitude");
        send({16'hABCE, 2'b00}, 1, 0, 4'd0, 32'h1111_2222, 16'h3344, 14'h0155, "R5 low bits ignored");
        send({16'h1357, 2'b01}, 1, 0, 4'd3, 32'h0BAD_F00D, 16'h7777, 14'h2222, "R6 R9 phase");
        send({16'hFFFF, 2'b10}, 1, 0, 4'd0, 32'hDEAD_BEEF, 16'h0102, 14'h0304, "R7 gain 0");
        send({16'h8001, 2'b10}, 1, 0, 4'd5, 32'hDEAD_BEEF, 16'h0102, 14'h0304, "R7 gain 5");
        send({16'hC003, 2'b10}, 1, 0, 4'd15, 32'h0, 16'h0, 14'h0, "R7 gain 15");
        send({16'h5AA5, 2'b11}, 1, 0, 4'd0, 32'h0F0F_0F0F, 16'h12C4, 14'h3F2A, "R8 polar");
        send({16'h0000, 2'b01}, 0, 0, 4'd0, 32'h0F0F_0F0F, 16'h12C4, 14'h3F2A, "R3 R4 idle hold");
        send({16'h0000, 2'b01}, 0, 0, 4'd0, 32'h0F0F_0F0F, 16'h12C4, 14'h3F2A, "R3 idle hold again");
        send({16'hFFFF, 2'b10}, 0, 1, 4'd2, 32'h0F0F_0F0F, 16'hBEEF, 14'h1FFF, "R3 R4 idle zero");
        send({16'h0F0F, 2'b01}, 1, 1, 4'd0, 32'hCAFE_0001, 16'h0000, 14'h0001, "R1 R6 resume");
        send({16'h2468, 2'b10}, 1, 0, 4'd8, 32'h0, 16'hAAAA, 14'h1555, "R7 R9 statics");
        send({16'hFFFF, 2'b00}, 1, 0, 4'd0, 32'h8000_0000, 16'hFFFF, 14'h0000, "R5 full scale");
        send({16'h00FF, 2'b11}, 0, 1, 4'd0, 32'h1, 16'h00FF, 14'h003F, "R4 R8 idle zero polar");
        repeat (3) @(posedge data_clk);
        repeat (4) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #200000;
        if (!done) begin
            done = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule